// File: doc/BRIEF.md
# Two-Stride Approximate Load Value Predictor

This block sits beside a core's first-level data cache and guesses the word that an approximable global load would have brought back from memory. A guess lets a miss complete at once, and nothing is rolled back if the guess is wrong. The table is indexed by a fold of the load's program counter mixed with its warp number. Each entry covers one cache line as two independent halves: the low sixteen words and the high sixteen words. Each half holds a value base, a value stride and a confirmation state.

Memory returns feed the training port. The first return sets the base. The second return gives a candidate stride. A third return with the same stride confirms the half. After that, lookups follow a repeating schedule: FETCH_N lookups are left to memory, then PREDICT_M lookups receive base plus stride. The base moves forward with every guess, so a strided run keeps going. A stride that breaks the pattern withdraws confirmation until it is seen twice in a row.

Top module: `vp_table`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pred_valid` and `pred_data` are zero. After reset every entry is empty, so no lookup produces a prediction until training has occurred.
- R2: The key is `pc ^ zero_extend(warp)`. The entry index is `key[IDXW-1:0] ^ key[2*IDXW-1:IDXW]`, and the stored tag is `key[PC_W-1:IDXW]`. A lookup whose tag differs from the one stored at its index produces no prediction and does not change that entry.
- R3: Bit 4 of the word index (the top bit, for 32-word lines) selects the half: 0 for words 0–15, 1 for words 16–31. Training or lookups on one half do not alter the other half.
- R4: On a training event to a half that already has a base, the new stride is the returned value minus the stored base, modulo 2^DATA_W. The base then becomes the returned value.
- R5: A half becomes confirmed only when two successive training strides are equal. That takes three returns from an empty half.
- R6: A training stride that differs from the stored stride removes confirmation and restarts the fetch/predict schedule. Two further equal strides are then needed before prediction resumes.
- R7: On a confirmed half, lookups cycle through a schedule: FETCH_N lookups without a prediction, then PREDICT_M lookups with one. A training event to a confirmed half with an unchanged stride leaves the schedule position unchanged.
- R8: The predicted value is base plus stride. Each prediction advances the base by the stride, so back-to-back predictions step by one stride each.
- R9: A training event whose tag does not match its index replaces the entry. The new tag is stored, the trained half starts again with the returned value as its base, and the other half is emptied.
- R10: When a lookup and a training event in the same cycle select the same entry, the lookup gives no prediction and does not advance the schedule. The training event takes effect as usual.
- R11: A prediction appears on `pred_valid`/`pred_data` exactly one cycle after the lookup that produced it. `pred_data` is zero whenever `pred_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request for a load miss |
| lk_pc | input | PC_W | Program counter of the looked-up load |
| lk_warp | input | WARP_W | Warp number of the looked-up load |
| lk_word | input | $clog2(LINE_WORDS) | Word index within the line |
| tr_valid | input | 1 | Training event (value returned from memory) |
| tr_pc | input | PC_W | Program counter of the returning load |
| tr_warp | input | WARP_W | Warp number of the returning load |
| tr_word | input | $clog2(LINE_WORDS) | Word index of the returned value |
| tr_data | input | DATA_W | Returned value |
| pred_valid | output | 1 | A prediction is being presented |
| pred_data | output | DATA_W | Predicted word, zero when not valid |

## Verification
A lookup and a training event can arrive in the same cycle and hit the same entry. This case decides both the lookup outcome and the schedule position. The bench provokes it by driving both ports at once, on a confirmed half that sits one step before its predict window, while the training stride matches. It then judges the result on the ports: the colliding lookup must show no prediction. The next lookup must also stay silent, and only the one after it predicts, from the base just trained. If the collision had consumed a schedule slot, that next lookup would have predicted.

// File: rtl/vp_pkg.sv
package vp_pkg;
  // Confirmation state of one half-line sub-predictor.
  typedef enum logic [1:0] {
    CONF_EMPTY   = 2'd0,  // no base captured yet
    CONF_BASE    = 2'd1,  // base known, no stride yet
    CONF_STRIDE  = 2'd2,  // stride seen once, not confirmed
    CONF_TRAINED = 2'd3   // stride seen twice in a row
  } conf_t;
endpackage

// File: rtl/vp_hash.sv
module vp_hash #(
  parameter int PC_W   = 16,
  parameter int WARP_W = 6,
  parameter int IDX_W  = 3,
  localparam int TAG_W = PC_W - IDX_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [WARP_W-1:0] warp,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  function automatic logic [PC_W-1:0] mix_key(logic [PC_W-1:0] p, logic [WARP_W-1:0] w);
    return p ^ PC_W'(w);
  endfunction

  function automatic logic [IDX_W-1:0] fold_index(logic [PC_W-1:0] k);
    return k[IDX_W-1:0] ^ k[2*IDX_W-1:IDX_W];
  endfunction

  logic [PC_W-1:0] key;
  assign key = mix_key(pc, warp);
  assign idx = fold_index(key);
  assign tag = key[PC_W-1:IDX_W];
endmodule

// File: rtl/vp_subpred.sv
module vp_subpred
  import vp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FETCH_N   = 9,
  parameter int PREDICT_M = 1,
  localparam int PH_W     = $clog2(FETCH_N + PREDICT_M + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,      // other half of entry is being replaced
  input  logic              tr_en,    // training value for this half
  input  logic              fresh,    // training replaces the entry
  input  logic [DATA_W-1:0] tr_data,
  input  logic              lk_en,    // tag-hit, collision-free lookup of this half
  output logic              fire,     // prediction issued this cycle
  output logic [DATA_W-1:0] pred_val
);
  localparam logic [PH_W-1:0] PH_FIRST_PRED = PH_W'(FETCH_N);
  localparam logic [PH_W-1:0] PH_LAST       = PH_W'(FETCH_N + PREDICT_M - 1);

  function automatic logic [DATA_W-1:0] step_value(logic [DATA_W-1:0] b, logic [DATA_W-1:0] s);
    return b + s;
  endfunction

  function automatic logic [DATA_W-1:0] value_delta(logic [DATA_W-1:0] v, logic [DATA_W-1:0] b);
    return v - b;
  endfunction

  conf_t             conf_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] stride_q;
  logic [PH_W-1:0]   phase_q;

  logic [DATA_W-1:0] new_stride;
  logic              stride_same;
  logic              in_window;

  assign new_stride  = value_delta(tr_data, base_q);
  assign stride_same = (new_stride == stride_q);
  assign in_window   = (phase_q >= PH_FIRST_PRED);
  assign pred_val    = step_value(base_q, stride_q);
  assign fire        = lk_en && (conf_q == CONF_TRAINED) && in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_q   <= CONF_EMPTY;
      base_q   <= '0;
      stride_q <= '0;
      phase_q  <= '0;
    end else if (clr) begin
      conf_q  <= CONF_EMPTY;
      phase_q <= '0;
    end else if (tr_en) begin
      base_q <= tr_data;
      if (fresh || conf_q == CONF_EMPTY) begin
        conf_q   <= CONF_BASE;
        stride_q <= '0;
        phase_q  <= '0;
      end else begin
        stride_q <= new_stride;
        if (conf_q == CONF_BASE) begin
          conf_q <= CONF_STRIDE;
        end else if (stride_same) begin
          conf_q <= CONF_TRAINED;
        end else begin
          conf_q  <= CONF_STRIDE;
          phase_q <= '0;
        end
      end
    end else if (lk_en && conf_q == CONF_TRAINED) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      if (fire) base_q <= pred_val;
    end
  end
endmodule

// File: rtl/vp_table.sv
module vp_table #(
  parameter int ENTRIES    = 8,
  parameter int PC_W       = 16,
  parameter int WARP_W     = 6,
  parameter int LINE_WORDS = 32,
  parameter int DATA_W     = 32,
  parameter int FETCH_N    = 9,
  parameter int PREDICT_M  = 1,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int TAG_W     = PC_W - IDX_W,
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int HALF_BIT  = WORD_W - 1,
  localparam int SUBS      = 2 * ENTRIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [WARP_W-1:0] lk_warp,
  input  logic [WORD_W-1:0] lk_word,
  input  logic              tr_valid,
  input  logic [PC_W-1:0]   tr_pc,
  input  logic [WARP_W-1:0] tr_warp,
  input  logic [WORD_W-1:0] tr_word,
  input  logic [DATA_W-1:0] tr_data,
  output logic              pred_valid,
  output logic [DATA_W-1:0] pred_data
);
  logic [IDX_W-1:0] lk_idx, tr_idx;
  logic [TAG_W-1:0] lk_tag, tr_tag;
  logic             lk_half, tr_half;

  vp_hash #(.PC_W(PC_W), .WARP_W(WARP_W), .IDX_W(IDX_W)) u_hash_lk (
    .pc(lk_pc), .warp(lk_warp), .idx(lk_idx), .tag(lk_tag)
  );
  vp_hash #(.PC_W(PC_W), .WARP_W(WARP_W), .IDX_W(IDX_W)) u_hash_tr (
    .pc(tr_pc), .warp(tr_warp), .idx(tr_idx), .tag(tr_tag)
  );

  assign lk_half = lk_word[HALF_BIT];
  assign tr_half = tr_word[HALF_BIT];

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] ent_v_q;

  // Named internal events, observed by the bound checker.
  logic lk_tag_hit, tr_tag_hit, tr_replace, lk_collide, lk_go, pred_fire;

  assign lk_tag_hit = ent_v_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign tr_tag_hit = ent_v_q[tr_idx] && (tag_q[tr_idx] == tr_tag);
  assign tr_replace = tr_valid && !tr_tag_hit;
  assign lk_collide = lk_valid && tr_valid && (lk_idx == tr_idx);
  assign lk_go      = lk_valid && lk_tag_hit && !lk_collide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v_q <= '0;
      for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
    end else if (tr_replace) begin
      ent_v_q[tr_idx] <= 1'b1;
      tag_q[tr_idx]   <= tr_tag;
    end
  end

  logic [SUBS-1:0]   fire_vec;
  logic [DATA_W-1:0] val_vec [SUBS];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic hit_ent_tr, hit_ent_lk;
      assign hit_ent_tr = (tr_idx == IDX_W'(e));
      assign hit_ent_lk = (lk_idx == IDX_W'(e));

      vp_subpred #(
        .DATA_W(DATA_W), .FETCH_N(FETCH_N), .PREDICT_M(PREDICT_M)
      ) u_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tr_replace && hit_ent_tr && (tr_half != 1'(h))),
        .tr_en   (tr_valid && hit_ent_tr && (tr_half == 1'(h))),
        .fresh   (tr_replace),
        .tr_data (tr_data),
        .lk_en   (lk_go && hit_ent_lk && (lk_half == 1'(h))),
        .fire    (fire_vec[2*e+h]),
        .pred_val(val_vec[2*e+h])
      );
    end
  end

  logic [IDX_W:0] lk_sel;
  assign lk_sel    = {lk_idx, lk_half};
  assign pred_fire = fire_vec[lk_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_data  <= '0;
    end else begin
      pred_valid <= pred_fire;
      pred_data  <= pred_fire ? val_vec[lk_sel] : '0;
    end
  end
endmodule

// File: rtl/vp_table_chk.sv
module vp_table_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_tag_hit,
  input logic              lk_collide,
  input logic              pred_valid,
  input logic [DATA_W-1:0] pred_data
);
  // R1: reset keeps the output quiet on the following edge
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !pred_valid);

  // R2: a tag miss never yields a prediction
  a_r2_tag_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_tag_hit) |=> !pred_valid);

  // R10: same-entry training and lookup suppress the prediction
  a_r10_collide_silent: assert property (@(posedge clk) disable iff (!rst_n)
    lk_collide |=> !pred_valid);

  // R11: a prediction always follows a lookup by one cycle
  a_r11_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(lk_valid));

  // R11: data is zero when nothing is predicted
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> (pred_data == '0));
endmodule

bind vp_table vp_table_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_tag_hit(lk_tag_hit),
  .lk_collide(lk_collide),
  .pred_valid(pred_valid),
  .pred_data (pred_data)
);

// File: tb/vp_table_test.sv
module vp_table_test;
  localparam int NV = 44;
  localparam int VW = 94;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_pc = '0;
  logic [5:0]  lk_warp = '0;
  logic [4:0]  lk_word = '0;
  logic        tr_valid = 1'b0;
  logic [15:0] tr_pc = '0;
  logic [5:0]  tr_warp = '0;
  logic [4:0]  tr_word = '0;
  logic [31:0] tr_data = '0;
  logic        pred_valid;
  logic [31:0] pred_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  vp_table #(.FETCH_N(2), .PREDICT_M(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_warp(lk_warp), .lk_word(lk_word),
    .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_warp(tr_warp), .tr_word(tr_word),
    .tr_data(tr_data), .pred_valid(pred_valid), .pred_data(pred_data)
  );

  // Key A: pc 0x0010 warp 1 -> index 3, tag 2. Key B: pc 0x0018 warp 0 -> index 3, tag 3.
  localparam logic [21:0] KA = {16'h0010, 6'd1};
  localparam logic [21:0] KB = {16'h0018, 6'd0};
  localparam logic [1:0]  LK = 2'b10;
  localparam logic [1:0]  TR = 2'b01;
  localparam logic [1:0]  LT = 2'b11;
  localparam logic [32:0] NP = 33'd0;

  // {ctl, pc, warp, word, train data, expected valid, expected data}
  localparam logic [VW-1:0] VEC [NV] = '{
    {LK, KA, 5'd3,  32'd0,   NP},
    {TR, KA, 5'd3,  32'd100, NP},
    {TR, KA, 5'd3,  32'd110, NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {TR, KA, 5'd3,  32'd120, NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   {1'b1, 32'd130}},
    {LK, KA, 5'd3,  32'd0,   {1'b1, 32'd140}},
    {LK, KA, 5'd3,  32'd0,   NP},
    {TR, KA, 5'd3,  32'd150, NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   {1'b1, 32'd160}},
    {LK, KA, 5'd20, 32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   {1'b1, 32'd170}},
    {TR, KA, 5'd20, 32'd5,   NP},
    {TR, KA, 5'd20, 32'd3,   NP},
    {TR, KA, 5'd20, 32'd1,   NP},
    {LK, KA, 5'd20, 32'd0,   NP},
    {LK, KA, 5'd20, 32'd0,   NP},
    {LK, KA, 5'd20, 32'd0,   {1'b1, 32'hFFFF_FFFF}},
    {LK, KA, 5'd3,  32'd0,   NP},
    {TR, KA, 5'd3,  32'd200, NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {TR, KA, 5'd3,  32'd230, NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   {1'b1, 32'd260}},
    {LK, KB, 5'd3,  32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   {1'b1, 32'd290}},
    {TR, KB, 5'd3,  32'd7,   NP},
    {LK, KA, 5'd20, 32'd0,   NP},
    {LK, KA, 5'd3,  32'd0,   NP},
    {TR, KB, 5'd3,  32'd9,   NP},
    {TR, KB, 5'd3,  32'd11,  NP},
    {LK, KB, 5'd3,  32'd0,   NP},
    {LK, KB, 5'd3,  32'd0,   NP},
    {LK, KB, 5'd3,  32'd0,   {1'b1, 32'd13}},
    {LK, KB, 5'd3,  32'd0,   {1'b1, 32'd15}},
    {LK, KB, 5'd3,  32'd0,   NP},
    {LT, KB, 5'd3,  32'd17,  NP},
    {LK, KB, 5'd3,  32'd0,   NP},
    {LK, KB, 5'd3,  32'd0,   {1'b1, 32'd19}}
  };

  function automatic string tag_of(int i);
    if (i == 0)  return "R1 empty table";
    if (i <= 4)  return "R5 confirmation";
    if (i <= 6)  return "R7 fetch phase";
    if (i <= 8)  return "R8 base advance";
    if (i == 9)  return "R7 schedule wrap";
    if (i <= 12) return "R4 stride training";
    if (i <= 20) return "R3 half independence";
    if (i <= 28) return "R6 stride break";
    if (i <= 30) return "R2 tag alias";
    if (i <= 40) return "R9 replacement";
    return "R10 same-cycle collision";
  endfunction

  task automatic check(string req, logic ev, logic [31:0] ed);
    tests++;
    if (pred_valid !== ev || pred_data !== ed) begin
      fails++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               req, pred_valid, pred_data, ev, ed);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet while reset is held
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", 1'b0, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      lk_valid = v[93];
      tr_valid = v[92];
      lk_pc = v[91:76];  tr_pc = v[91:76];
      lk_warp = v[75:70]; tr_warp = v[75:70];
      lk_word = v[69:65]; tr_word = v[69:65];
      tr_data = v[64:33];
      @(posedge clk);
      #1 check(tag_of(i), v[32], v[31:0]);
    end

    // R11: prediction lasts one cycle after its lookup; schedule slot 3 of key B predicts 21
    @(negedge clk);
    lk_valid = 1'b1; tr_valid = 1'b0;
    lk_pc = KB[21:6]; lk_warp = KB[5:0]; lk_word = 5'd3;
    @(posedge clk);
    #1 check("R11 one-cycle latency", 1'b1, 32'd21);
    @(negedge clk) lk_valid = 1'b0;
    @(posedge clk);
    #1 check("R11 pulse ends, data zero", 1'b0, 32'd0);

    // R1: reset mid-run empties the table
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 check("R1 reset clears output", 1'b0, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lk_valid = 1'b1; lk_pc = KB[21:6]; lk_warp = KB[5:0]; lk_word = 5'd3;
      @(posedge clk);
      #1 check("R1 no prediction after reset", 1'b0, 32'd0);
    end
    @(negedge clk) lk_valid = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule